// File: doc/BRIEF.md
# Atomic Read-Modify-Write Execution Unit

This unit carries out one atomic memory update at a time on a single-port, 64-bit-wide word memory. A requester presents an opcode, a data size, a byte address and two operands (B and C). The unit fetches the addressed word and returns the value it held before the update. It computes the replacement value and stores it in the cycle right after the read, so no other access can reach the memory between the two.

Supported integer operations are add, signed and unsigned min and max, bounded wrapping increment and decrement, bitwise and, or and xor, exchange, and compare-and-swap. Data may be 32 or 64 bits wide. A 32-bit access uses one half of the memory word, chosen by address bit 2, and writes it with byte enables. Requests that are not aligned to their size, or that name an unsupported opcode/size pairing, complete with an error code and leave memory untouched.

Top module: `atomic_rmw_unit`

## Requirements
- R1: `req_ready` is high only while the unit is idle; a request is taken on a rising edge where `req_valid` and `req_ready` are both high, and `rsp_valid` is then high for exactly one cycle before `req_ready` returns.
- R2: Every successful response carries in `rsp_old` the memory value before the update, zero-extended to 64 bits for 32-bit sizes, with `rsp_err` = 0.
- R3: Add stores old+B, and/or/xor store the bitwise result with B, exchange stores B (opcodes 0, 5, 6, 7, 8).
- R4: Min (opcode 1) and max (opcode 2) compare as signed for sizes 1 (32-bit) and 3 (64-bit) and as unsigned for sizes 0 (32-bit) and 2 (64-bit).
- R5: Increment (opcode 3, size 0 only) stores 0 when old >= B (unsigned), otherwise old+1.
- R6: Decrement (opcode 4, size 0 only) stores B when old is 0 or old > B, otherwise old-1.
- R7: Compare-and-swap (opcode 9) stores C only when old equals B; on mismatch no write is issued and only the read touches memory.
- R8: Memory is little-endian: a 32-bit access with address bit 2 = 0 uses bits 31:0 with `mem_be` = 0x0F, with bit 2 = 1 uses bits 63:32 with `mem_be` = 0xF0; the other half is unchanged. 64-bit accesses use `mem_be` = 0xFF.
- R9: An address not a multiple of 4 (32-bit) or 8 (64-bit) gives `rsp_err` = 1, `rsp_old` = 0, no memory access.
- R10: Opcodes above 9, or increment/decrement with any size other than 0, give `rsp_err` = 2 with no memory access; this code takes priority over the misalignment code.
- R11: A write is issued only in the cycle right after a read of the same word, and the memory port is idle while the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_op | input | 4 | Opcode (0 add, 1 min, 2 max, 3 inc, 4 dec, 5 and, 6 or, 7 xor, 8 exchange, 9 compare-and-swap) |
| req_size | input | 2 | 0 unsigned 32, 1 signed 32, 2 unsigned 64, 3 signed 64 |
| req_addr | input | ADDR_W | Byte address |
| req_opb | input | 64 | Operand B |
| req_opc | input | 64 | Operand C (compare-and-swap new value) |
| rsp_valid | output | 1 | Response present, one cycle |
| rsp_old | output | 64 | Prior memory value |
| rsp_err | output | 2 | 0 ok, 1 misaligned, 2 illegal operation |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | ADDR_W-3 | Word address |
| mem_be | output | 8 | Byte enables for writes |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, one cycle after a read |

## Verification
Counting the accepting edge as edge zero, the read strobe is up in the cycle after it, the write strobe in the cycle after that, and a successful response is visible after the second following edge; an error response is visible right after the accepting edge itself. Each directed task samples on falling edges, indexes those samples from the first falling edge after acceptance, and expects the response at index 2 (or 0 for errors) while counting memory strobes seen at every index. After the response the bench compares its own memory model word against the value computed by hand from the requirement, so untouched halves and skipped writes are checked as well.

// File: rtl/atom_pkg.sv
package atom_pkg;
  localparam int DATA_W = 64;
  localparam int HALF_W = DATA_W / 2;
  localparam int BE_W   = DATA_W / 8;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_MIN  = 4'd1,
    OP_MAX  = 4'd2,
    OP_INC  = 4'd3,
    OP_DEC  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_EXCH = 4'd8,
    OP_CAS  = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    SZ_U32 = 2'd0,
    SZ_S32 = 2'd1,
    SZ_U64 = 2'd2,
    SZ_S64 = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_ALIGN   = 2'd1,
    ERR_ILLEGAL = 2'd2
  } err_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_MODIFY = 2'd2,
    ST_RESP   = 2'd3
  } state_e;
endpackage

// File: rtl/atom_decode.sv
module atom_decode
  import atom_pkg::*;
(
  input  logic [3:0] op,
  input  logic [1:0] size,
  input  logic [2:0] addr_lo,
  output logic [1:0] err
);
  logic illegal;
  logic misaligned;

  always_comb begin
    illegal = (op > OP_CAS);
    if ((op == OP_INC || op == OP_DEC) && size != SZ_U32) illegal = 1'b1;
    misaligned = size[1] ? (addr_lo != 3'd0) : (addr_lo[1:0] != 2'd0);
    if (illegal)         err = ERR_ILLEGAL;
    else if (misaligned) err = ERR_ALIGN;
    else                 err = ERR_NONE;
  end
endmodule

// File: rtl/atom_lane.sv
module atom_lane
  import atom_pkg::*;
(
  input  logic              is64,
  input  logic              sel_hi,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] new_val,
  output logic [DATA_W-1:0] old_val,
  output logic [DATA_W-1:0] wdata,
  output logic [BE_W-1:0]   be
);
  localparam int HALF_BE = BE_W / 2;

  logic [HALF_W-1:0] half_sel;

  always_comb begin
    half_sel = sel_hi ? rdata[DATA_W-1:HALF_W] : rdata[HALF_W-1:0];
    old_val  = is64 ? rdata : {{HALF_W{1'b0}}, half_sel};
    wdata    = is64 ? new_val : {new_val[HALF_W-1:0], new_val[HALF_W-1:0]};
  end

  for (genvar g = 0; g < BE_W; g++) begin : g_be
    if (g < HALF_BE) begin : g_lo
      assign be[g] = is64 | ~sel_hi;
    end else begin : g_hi
      assign be[g] = is64 | sel_hi;
    end
  end
endmodule

// File: rtl/atom_alu.sv
module atom_alu
  import atom_pkg::*;
(
  input  logic [3:0]        op,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] opc,
  output logic [DATA_W-1:0] result,
  output logic              wr_ok
);
  logic              is64;
  logic              sgn;
  logic              lt;
  logic              eq;
  logic [HALF_W-1:0] a32;
  logic [HALF_W-1:0] b32;

  always_comb begin
    is64 = size[1];
    sgn  = size[0];
    a32  = cur[HALF_W-1:0];
    b32  = opb[HALF_W-1:0];
    if (is64) lt = sgn ? ($signed(cur) < $signed(opb)) : (cur < opb);
    else      lt = sgn ? ($signed(a32) < $signed(b32)) : (a32 < b32);
    eq = is64 ? (cur == opb) : (a32 == b32);

    wr_ok  = 1'b1;
    result = cur;
    case (op)
      OP_ADD:  result = cur + opb;
      OP_MIN:  result = lt ? cur : opb;
      OP_MAX:  result = lt ? opb : cur;
      OP_INC:  result = (a32 >= b32) ? '0 : {{HALF_W{1'b0}}, a32 + 32'd1};
      OP_DEC:  result = (a32 == '0 || a32 > b32) ? {{HALF_W{1'b0}}, b32}
                                                 : {{HALF_W{1'b0}}, a32 - 32'd1};
      OP_AND:  result = cur & opb;
      OP_OR:   result = cur | opb;
      OP_XOR:  result = cur ^ opb;
      OP_EXCH: result = opb;
      OP_CAS: begin
        result = opc;
        wr_ok  = eq;
      end
      default: wr_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atom_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_op,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_opb,
  input  logic [63:0]       req_opc,
  output logic              rsp_valid,
  output logic [63:0]       rsp_old,
  output logic [1:0]        rsp_err,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-4:0] mem_addr,
  output logic [7:0]        mem_be,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata
);
  localparam int WORD_AW = ADDR_W - 3;

  state_e              state_q, state_d;
  logic [3:0]          op_q;
  logic [1:0]          size_q;
  logic [ADDR_W-1:2]   addr_q;
  logic [DATA_W-1:0]   opb_q, opc_q;
  logic [DATA_W-1:0]   old_q, old_d;
  logic [1:0]          err_q, err_d;
  logic                load_req;
  logic                load_rsp;
  logic [1:0]          dec_err;
  logic [DATA_W-1:0]   lane_old;
  logic [DATA_W-1:0]   alu_res;
  logic                alu_wr;

  atom_decode u_decode (
    .op      (req_op),
    .size    (req_size),
    .addr_lo (req_addr[2:0]),
    .err     (dec_err)
  );

  atom_lane u_lane (
    .is64    (size_q[1]),
    .sel_hi  (addr_q[2]),
    .rdata   (mem_rdata),
    .new_val (alu_res),
    .old_val (lane_old),
    .wdata   (mem_wdata),
    .be      (mem_be)
  );

  atom_alu u_alu (
    .op     (op_q),
    .size   (size_q),
    .cur    (lane_old),
    .opb    (opb_q),
    .opc    (opc_q),
    .result (alu_res),
    .wr_ok  (alu_wr)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign load_req  = req_valid & req_ready;
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_old   = old_q;
  assign rsp_err   = err_q;
  assign mem_addr  = addr_q[ADDR_W-1:3];
  assign mem_we    = (state_q == ST_MODIFY) & alu_wr;
  assign mem_en    = (state_q == ST_READ) | mem_we;

  // next-state and response capture
  always_comb begin
    state_d  = state_q;
    old_d    = old_q;
    err_d    = err_q;
    load_rsp = 1'b0;
    case (state_q)
      ST_IDLE: if (load_req) begin
        load_rsp = 1'b1;
        err_d    = dec_err;
        old_d    = '0;
        state_d  = (dec_err == ERR_NONE) ? ST_READ : ST_RESP;
      end
      ST_READ:   state_d = ST_MODIFY;
      ST_MODIFY: begin
        load_rsp = 1'b1;
        old_d    = lane_old;
        state_d  = ST_RESP;
      end
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      old_q   <= '0;
      err_q   <= ERR_NONE;
    end else begin
      state_q <= state_d;
      if (load_rsp) begin
        old_q <= old_d;
        err_q <= err_d;
      end
    end
  end

  // request capture, data path only
  always_ff @(posedge clk) begin
    if (load_req) begin
      op_q   <= req_op;
      size_q <= req_size;
      addr_q <= req_addr[ADDR_W-1:2];
      opb_q  <= req_opb;
      opc_q  <= req_opc;
    end
  end

  logic unused_width;
  assign unused_width = (WORD_AW > 0) ? 1'b0 : 1'b1;
endmodule

// File: rtl/atom_rmw_chk.sv
module atom_rmw_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [3:0]        req_op,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [1:0]        rsp_err,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-4:0] mem_addr,
  input logic [7:0]        mem_be
);
  // R1
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R1
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R1
  no_ready_during_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R11
  write_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> ($past(mem_en && !mem_we) && $past(mem_addr) == mem_addr));

  // R11
  idle_port_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_en);

  // R8
  byte_enable_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (mem_be == 8'h0F || mem_be == 8'hF0 || mem_be == 8'hFF));

  // R9
  misaligned_add64_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 4'd0 && req_size == 2'd2 && req_addr[2:0] != 3'd0)
      |=> (rsp_valid && rsp_err == 2'd1));

  // R10
  illegal_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op > 4'd9) |=> (rsp_valid && rsp_err == 2'd2 && !mem_en));
endmodule

bind atomic_rmw_unit atom_rmw_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .req_size  (req_size),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be)
);

// File: tb/tb_atomic_rmw_unit.sv
`timescale 1ns/1ps
module tb_atomic_rmw_unit;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [3:0]        req_op = '0;
  logic [1:0]        req_size = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [63:0]       req_opb = '0;
  logic [63:0]       req_opc = '0;
  logic              rsp_valid;
  logic [63:0]       rsp_old;
  logic [1:0]        rsp_err;
  logic              mem_en;
  logic              mem_we;
  logic [ADDR_W-4:0] mem_addr;
  logic [7:0]        mem_be;
  logic [63:0]       mem_wdata;
  logic [63:0]       mem_rdata;

  logic [63:0] mem [0:63];
  logic        pl_en = 1'b0;
  logic [5:0]  pl_idx = '0;
  logic [63:0] pl_data = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  atomic_rmw_unit #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_size(req_size), .req_addr(req_addr),
    .req_opb(req_opb), .req_opc(req_opc),
    .rsp_valid(rsp_valid), .rsp_old(rsp_old), .rsp_err(rsp_err),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: one-cycle read latency, byte-enabled writes
  always @(posedge clk) begin
    if (pl_en) mem[pl_idx] <= pl_data;
    else if (mem_en) begin
      if (mem_we) begin
        for (int k = 0; k < 8; k++)
          if (mem_be[k]) mem[mem_addr[5:0]][k*8 +: 8] <= mem_wdata[k*8 +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[5:0]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic preload(input int idx, input logic [63:0] val);
    @(negedge clk);
    pl_en = 1'b1; pl_idx = idx[5:0]; pl_data = val;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  task automatic do_op(input logic [3:0] op, input logic [1:0] sz, input logic [15:0] addr,
                       input logic [63:0] b, input logic [63:0] c,
                       input logic [63:0] exp_old, input logic [1:0] exp_err,
                       input logic [63:0] exp_word, input int exp_acc, input string req);
    int first;
    int acc;
    logic [63:0] got_old;
    logic [1:0]  got_err;
    int exp_lat;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready before request", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1; req_op = op; req_size = sz; req_addr = addr;
    req_opb = b; req_opc = c;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1", "ready after accept", {63'd0, req_ready}, 64'd0);
    first = -1; acc = 0; got_old = '0; got_err = '0;
    for (int i = 0; i < 5; i++) begin
      if (i > 0) @(negedge clk);
      if (mem_en) acc++;
      if (rsp_valid && first < 0) begin
        first = i; got_old = rsp_old; got_err = rsp_err;
      end
    end
    exp_lat = (exp_err != 2'd0) ? 0 : 2;
    chk(first == exp_lat, req, "response latency", 64'(first), 64'(exp_lat));
    chk(got_err == exp_err, req, "error code", {62'd0, got_err}, {62'd0, exp_err});
    chk(got_old == exp_old, req, "old value", got_old, exp_old);
    chk(acc == exp_acc, req, "memory accesses", 64'(acc), 64'(exp_acc));
    chk(mem[addr[8:3]] == exp_word, req, "memory word", mem[addr[8:3]], exp_word);
    chk(req_ready == 1'b1, "R1", "ready after response", {63'd0, req_ready}, 64'd1);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1", "reset ready", {63'd0, req_ready}, 64'd1);
    chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk(mem_en == 1'b0, "R11", "reset mem_en", {63'd0, mem_en}, 64'd0);
  endtask

  task automatic t_arith_logic();
    preload(1, 64'h0000_0001_FFFF_FFFF);
    do_op(4'd0, 2'd2, 16'h0008, 64'd1, 64'd0, 64'h0000_0001_FFFF_FFFF, 2'd0,
          64'h0000_0002_0000_0000, 2, "R3 R2 add64");
    preload(3, 64'h1234_0000_0000_5678);
    do_op(4'd6, 2'd2, 16'h0018, 64'h0000_8000_0001_0000, 64'd0, 64'h1234_0000_0000_5678, 2'd0,
          64'h1234_8000_0001_5678, 2, "R3 or64");
    do_op(4'd7, 2'd1, 16'h0018, 64'h0000_0000_FFFF_FFFF, 64'd0, 64'h0000_0000_0001_5678, 2'd0,
          64'h1234_8000_FFFE_A987, 2, "R3 xor32");
    preload(4, 64'd5);
    do_op(4'd8, 2'd2, 16'h0020, 64'hDEAD_BEEF_0123_4567, 64'd0, 64'd5, 2'd0,
          64'hDEAD_BEEF_0123_4567, 2, "R3 exch64");
  endtask

  task automatic t_lanes();
    preload(2, 64'hAAAA_AAAA_FFFF_FFF0);
    do_op(4'd0, 2'd0, 16'h0014, 64'hFFFF_FFFF_0000_0006, 64'd0, 64'h0000_0000_AAAA_AAAA, 2'd0,
          64'hAAAA_AAB0_FFFF_FFF0, 2, "R8 add32 upper half");
    do_op(4'd5, 2'd0, 16'h0010, 64'h0000_0000_0F0F_0F0F, 64'd0, 64'h0000_0000_FFFF_FFF0, 2'd0,
          64'hAAAA_AAB0_0F0F_0F00, 2, "R8 and32 lower half");
  endtask

  task automatic t_minmax();
    preload(5, 64'h0000_0000_8000_0000);
    do_op(4'd1, 2'd1, 16'h0028, 64'd5, 64'd0, 64'h8000_0000, 2'd0, 64'h8000_0000, 2, "R4 min s32");
    do_op(4'd1, 2'd0, 16'h0028, 64'd5, 64'd0, 64'h8000_0000, 2'd0, 64'd5, 2, "R4 min u32");
    do_op(4'd2, 2'd1, 16'h0028, 64'hFFFF_FFFF, 64'd0, 64'd5, 2'd0, 64'd5, 2, "R4 max s32");
    do_op(4'd2, 2'd0, 16'h0028, 64'hFFFF_FFFF, 64'd0, 64'd5, 2'd0, 64'hFFFF_FFFF, 2, "R4 max u32");
    preload(6, 64'hFFFF_FFFF_FFFF_FFFE);
    do_op(4'd1, 2'd3, 16'h0030, 64'd3, 64'd0, 64'hFFFF_FFFF_FFFF_FFFE, 2'd0,
          64'hFFFF_FFFF_FFFF_FFFE, 2, "R4 min s64");
    do_op(4'd2, 2'd3, 16'h0030, 64'd3, 64'd0, 64'hFFFF_FFFF_FFFF_FFFE, 2'd0, 64'd3, 2, "R4 max s64");
    do_op(4'd2, 2'd2, 16'h0030, 64'h8000_0000_0000_0000, 64'd0, 64'd3, 2'd0,
          64'h8000_0000_0000_0000, 2, "R4 max u64");
    do_op(4'd1, 2'd2, 16'h0030, 64'd7, 64'd0, 64'h8000_0000_0000_0000, 2'd0, 64'd7, 2, "R4 min u64");
  endtask

  task automatic t_inc();
    preload(7, 64'd0);
    do_op(4'd3, 2'd0, 16'h0038, 64'd2, 64'd0, 64'd0, 2'd0, 64'd1, 2, "R5 inc step");
    do_op(4'd3, 2'd0, 16'h0038, 64'd2, 64'd0, 64'd1, 2'd0, 64'd2, 2, "R5 inc step");
    do_op(4'd3, 2'd0, 16'h0038, 64'd2, 64'd0, 64'd2, 2'd0, 64'd0, 2, "R5 inc wrap");
  endtask

  task automatic t_dec();
    preload(8, 64'd0);
    do_op(4'd4, 2'd0, 16'h0040, 64'd3, 64'd0, 64'd0, 2'd0, 64'd3, 2, "R6 dec from zero");
    do_op(4'd4, 2'd0, 16'h0040, 64'd3, 64'd0, 64'd3, 2'd0, 64'd2, 2, "R6 dec step");
    do_op(4'd4, 2'd0, 16'h0040, 64'd1, 64'd0, 64'd2, 2'd0, 64'd1, 2, "R6 dec above bound");
    do_op(4'd4, 2'd0, 16'h0040, 64'd1, 64'd0, 64'd1, 2'd0, 64'd0, 2, "R6 dec to zero");
  endtask

  task automatic t_cas();
    preload(9, 64'h11);
    do_op(4'd9, 2'd2, 16'h0048, 64'h11, 64'h99, 64'h11, 2'd0, 64'h99, 2, "R7 cas match");
    do_op(4'd9, 2'd2, 16'h0048, 64'h11, 64'h55, 64'h99, 2'd0, 64'h99, 1, "R7 cas mismatch");
    do_op(4'd9, 2'd0, 16'h004C, 64'd0, 64'd7, 64'd0, 2'd0, 64'h0000_0007_0000_0099, 2, "R7 cas32 upper");
  endtask

  task automatic t_misaligned();
    do_op(4'd0, 2'd0, 16'h0042, 64'd1, 64'd0, 64'd0, 2'd1, 64'd0, 0, "R9 misaligned 32");
    do_op(4'd0, 2'd2, 16'h0044, 64'd1, 64'd0, 64'd0, 2'd1, 64'd0, 0, "R9 misaligned 64");
  endtask

  task automatic t_illegal();
    do_op(4'd3, 2'd2, 16'h0038, 64'd9, 64'd0, 64'd0, 2'd2, 64'd0, 0, "R10 inc on 64-bit");
    do_op(4'd15, 2'd0, 16'h0038, 64'd9, 64'd0, 64'd0, 2'd2, 64'd0, 0, "R10 bad opcode");
    do_op(4'd3, 2'd2, 16'h003C, 64'd9, 64'd0, 64'd0, 2'd2, 64'd0, 0, "R10 priority over misalign");
    do_op(4'd4, 2'd1, 16'h0040, 64'd9, 64'd0, 64'd0, 2'd2, 64'd0, 0, "R10 dec signed");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arith_logic();
    t_lanes();
    t_minmax();
    t_inc();
    t_dec();
    t_cas();
    t_misaligned();
    t_illegal();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule